// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel position inside a two-dimensional tiled memory container into the 32-bit address that a client uses to reach that pixel through one of eight rotated or mirrored views. Each request carries a pixel format code, a 3-bit orientation code and an (x, y) coordinate. The orientation code goes into the top three address bits and the format code into the next two. The coordinate offset fills the bits below them. The block also returns the row stride that goes with the chosen format and orientation.

The offset is built in four steps. The usable x and y widths are derived from the container size and from per-format shift amounts. Each axis is mirrored by inverting all of its usable bits. The row and column terms are swapped when the orientation asks for it. The result is then scaled to the format's byte alignment. A coordinate outside the usable range gives an all-zero address and a range flag. The page-mode format code is refused: it sets an error flag and gives a zero address and a zero stride. The result can be registered, which adds one cycle between the input valid and the output valid.

Top module: `tview_addr_gen`

## Requirements
- R1: For format codes 0 (8-bit), 1 (16-bit) and 2 (32-bit), with the coordinate in range, address bits [28:27] equal the format code.
- R2: For an accepted request, address bits [31:29] equal the 3-bit orientation code.
- R3: With orientation bit 2 clear, address bits [26:0] equal ((y << xb) + x) << (xs + ys). Here (xs, ys) is (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit, xb = 14 - xs and yb = 13 - ys (default container of 14 width bits and 13 height bits). As a result the lowest xs + ys address bits are zero.
- R4: With orientation bit 2 set, the axes are swapped: the offset before scaling is (x << yb) + y.
- R5: Orientation bit 0 replaces x with x XOR (2^xb - 1), and orientation bit 1 replaces y with y XOR (2^yb - 1). Both are applied before the swap and the packing.
- R6: If x > 2^xb - 1 or y > 2^yb - 1, the address is zero and range_err is 1. The stride is still given.
- R7: Format code 3 (page mode) sets fmt_err to 1 and gives an address of zero and a stride of zero; range_err stays 0.
- R8: For formats 0 to 2, the stride is 1 << (13 + xs) when orientation bit 2 is set and 1 << (14 + ys) when it is clear.
- R9: With the registered output (default), out_valid follows in_valid exactly one cycle later, together with the result of that request. Reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| fmt | input | 2 | Pixel format code (0 8-bit, 1 16-bit, 2 32-bit, 3 page) |
| orient | input | 3 | Orientation: bit0 x-invert, bit1 y-invert, bit2 axis swap |
| x_in | input | CRD_W (16) | Pixel column |
| y_in | input | CRD_W (16) | Pixel row |
| out_valid | output | 1 | Result present |
| addr | output | 32 | Tiled-space address |
| stride | output | 32 | Row stride in bytes for this view |
| range_err | output | 1 | Coordinate outside the container |
| fmt_err | output | 1 | Page-mode format refused |

## Verification
The assertions check on every cycle the one-cycle valid latency, that the format and view fields follow the request, that a flagged result carries a zero address, that a refused format carries a zero stride, that a stride is a single power of two, and that the offset is zero in the alignment bits. Only the bench's scenarios show that the offset holds the right arithmetic value. This covers the mirroring about the correct mask, the swapped packing, the exact mask boundary for each format, and the stride value itself. For these the bench compares against a model that it computes on its own.

// File: rtl/tva_pkg.sv
// Shared types for the tiled view address generator.
// Assumes the view field sits in address bits [31:29] and the format field in [28:27].
package tva_pkg;

    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } tva_fmt_e;

    localparam int VIEW_LSB  = 29;
    localparam int FMT_LSB   = 27;
    localparam int OFFSET_W  = 27;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] stride;
        logic        range_err;
        logic        fmt_err;
    } tva_result_t;

endpackage

// File: rtl/tva_fmt_decode.sv
// Maps a format code to its x/y alignment shifts and flags the refused page mode.
// Assumes shifts are at most 1 bit per axis.
module tva_fmt_decode (
    input  logic [1:0] fmt,
    output logic       xs,
    output logic       ys,
    output logic       fmt_err
);
    import tva_pkg::*;

    // decode the per-format shift pair
    always_comb begin
        xs      = 1'b0;
        ys      = 1'b0;
        fmt_err = 1'b0;
        case (tva_fmt_e'(fmt))
            FMT_B8:   begin xs = 1'b0; ys = 1'b0; end
            FMT_B16:  begin xs = 1'b0; ys = 1'b1; end
            FMT_B32:  begin xs = 1'b1; ys = 1'b1; end
            default:  fmt_err = 1'b1;
        endcase
    end

endmodule

// File: rtl/tva_offset.sv
// Mirrors, optionally swaps and packs a coordinate into a tiled address; also gives the stride.
// Assumes W_BITS + H_BITS <= 27 and CRD_W > W_BITS.
module tva_offset #(
    parameter int W_BITS = 14,
    parameter int H_BITS = 13,
    parameter int CRD_W  = 16
) (
    input  logic [1:0]           fmt,
    input  logic [2:0]           orient,
    input  logic [CRD_W-1:0]     x_in,
    input  logic [CRD_W-1:0]     y_in,
    input  logic                 xs,
    input  logic                 ys,
    input  logic                 fmt_err,
    output tva_pkg::tva_result_t res
);
    import tva_pkg::*;

    localparam int OFF_W = W_BITS + H_BITS;

    logic [CRD_W-1:0] x_mask;
    logic [CRD_W-1:0] y_mask;
    logic [CRD_W-1:0] x_m;
    logic [CRD_W-1:0] y_m;
    logic             in_range;
    logic [OFF_W-1:0] off_raw;
    logic [OFF_W-1:0] off_al;
    logic [31:0]      stride_c;

    // usable-coordinate masks for the selected format
    always_comb begin
        x_mask = (CRD_W'(1) << (W_BITS - int'(xs))) - CRD_W'(1);
        y_mask = (CRD_W'(1) << (H_BITS - int'(ys))) - CRD_W'(1);
    end

    // range test on the unmirrored coordinate
    assign in_range = (x_in <= x_mask) && (y_in <= y_mask);

    // per-axis mirroring by inverting the usable bits
    always_comb begin
        x_m = orient[0] ? (x_in ^ x_mask) : x_in;
        y_m = orient[1] ? (y_in ^ y_mask) : y_in;
    end

    // row/column packing with optional swap, then alignment scaling
    always_comb begin
        if (orient[2])
            off_raw = (OFF_W'(x_m) << (H_BITS - int'(ys))) + OFF_W'(y_m);
        else
            off_raw = (OFF_W'(y_m) << (W_BITS - int'(xs))) + OFF_W'(x_m);
        off_al = off_raw << (int'(xs) + int'(ys));
    end

    // row stride for the view
    assign stride_c = orient[2] ? (32'd1 << (H_BITS + int'(xs)))
                                : (32'd1 << (W_BITS + int'(ys)));

    // assemble the result with error precedence
    always_comb begin
        res = '0;
        if (fmt_err) begin
            res.fmt_err = 1'b1;
        end else begin
            res.stride = stride_c;
            if (!in_range)
                res.range_err = 1'b1;
            else
                res.addr = {orient, fmt, OFFSET_W'(off_al)};
        end
    end

endmodule

// File: rtl/tva_out_stage.sv
// Optional output register; REG_OUT=0 passes the result straight through.
// Assumes synchronous active-low reset; the result is held while in_valid is low.
module tva_out_stage #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  tva_pkg::tva_result_t res_d,
    output logic                 out_valid,
    output tva_pkg::tva_result_t res_q
);
    generate
        if (REG_OUT) begin : g_reg
            logic                 vld_r;
            tva_pkg::tva_result_t res_r;

            // capture a result on each accepted request
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_r <= 1'b0;
                    res_r <= '0;
                end else begin
                    vld_r <= in_valid;
                    if (in_valid)
                        res_r <= res_d;
                end
            end

            assign out_valid = vld_r;
            assign res_q     = res_r;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign res_q     = res_d;
        end
    endgenerate

endmodule

// File: rtl/tview_addr_gen.sv
// Tiled view address generator top: format decode, offset build, optional register.
// Assumes the default container (14 x 13 bits) fits the 27-bit offset field.
module tview_addr_gen #(
    parameter int W_BITS  = 14,
    parameter int H_BITS  = 13,
    parameter int CRD_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       fmt,
    input  logic [2:0]       orient,
    input  logic [CRD_W-1:0] x_in,
    input  logic [CRD_W-1:0] y_in,
    output logic             out_valid,
    output logic [31:0]      addr,
    output logic [31:0]      stride,
    output logic             range_err,
    output logic             fmt_err
);
    import tva_pkg::*;

    logic        xs;
    logic        ys;
    logic        fmt_bad;
    tva_result_t res_d;
    tva_result_t res_q;

    tva_fmt_decode u_dec (
        .fmt     (fmt),
        .xs      (xs),
        .ys      (ys),
        .fmt_err (fmt_bad)
    );

    tva_offset #(
        .W_BITS (W_BITS),
        .H_BITS (H_BITS),
        .CRD_W  (CRD_W)
    ) u_off (
        .fmt     (fmt),
        .orient  (orient),
        .x_in    (x_in),
        .y_in    (y_in),
        .xs      (xs),
        .ys      (ys),
        .fmt_err (fmt_bad),
        .res     (res_d)
    );

    tva_out_stage #(
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .res_d     (res_d),
        .out_valid (out_valid),
        .res_q     (res_q)
    );

    // unpack the result onto the ports
    assign addr      = res_q.addr;
    assign stride    = res_q.stride;
    assign range_err = res_q.range_err;
    assign fmt_err   = res_q.fmt_err;

endmodule

// File: rtl/tva_addr_chk.sv
// Protocol and field checks for tview_addr_gen, attached by bind.
// Assumes the registered variant for the latency properties.
module tva_addr_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  fmt,
    input logic [2:0]  orient,
    input logic        out_valid,
    input logic [31:0] addr,
    input logic [31:0] stride,
    input logic        range_err,
    input logic        fmt_err
);
    generate
        if (REG_OUT) begin : g_chk
            assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && in_valid) |=> out_valid);
            assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && !in_valid) |=> !out_valid);
            assert_fmt_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && in_valid) |=> (fmt_err || range_err || addr[28:27] == $past(fmt)));
            assert_view_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && in_valid) |=> (fmt_err || range_err || addr[31:29] == $past(orient)));
        end
    endgenerate

    assert_align_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fmt_err && !range_err && addr[28:27] == 2'd2) |-> addr[1:0] == 2'b00);
    assert_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && range_err) |-> (addr == 32'd0 && !fmt_err));
    assert_page_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_err) |-> (addr == 32'd0 && stride == 32'd0 && !range_err));
    assert_stride_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fmt_err) |-> $countones(stride) == 1);

endmodule

bind tview_addr_gen tva_addr_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fmt       (fmt),
    .orient    (orient),
    .out_valid (out_valid),
    .addr      (addr),
    .stride    (stride),
    .range_err (range_err),
    .fmt_err   (fmt_err)
);

// File: tb/tview_addr_gen_tb.sv
module tview_addr_gen_tb;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] stride;
        logic        rerr;
        logic        ferr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [2:0]  orient = 3'd0;
    logic [15:0] x_in = 16'd0;
    logic [15:0] y_in = 16'd0;
    logic        out_valid;
    logic [31:0] addr;
    logic [31:0] stride;
    logic        range_err;
    logic        fmt_err;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    tview_addr_gen #(.W_BITS(14), .H_BITS(13), .CRD_W(16), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
        .x_in(x_in), .y_in(y_in), .out_valid(out_valid), .addr(addr),
        .stride(stride), .range_err(range_err), .fmt_err(fmt_err)
    );

    // Independent model of the requirements
    function automatic exp_t model(int f, int o, int x, int y, string tag);
        exp_t e;
        int xs, ys, xb, yb, xm, ym, xx, yy;
        longint off;
        e.tag = tag; e.addr = 0; e.stride = 0; e.rerr = 0; e.ferr = 0;
        if (f == 3) begin
            e.ferr = 1;
            return e;
        end
        xs = (f == 2) ? 1 : 0;
        ys = (f >= 1) ? 1 : 0;
        xb = 14 - xs; yb = 13 - ys;
        xm = (1 << xb) - 1; ym = (1 << yb) - 1;
        e.stride = (o >= 4) ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
        if (x > xm || y > ym) begin
            e.rerr = 1;
            return e;
        end
        xx = (o % 2 == 1) ? (xm - x) : x;
        yy = ((o / 2) % 2 == 1) ? (ym - y) : y;
        if (o >= 4) off = longint'(xx) * (longint'(1) << yb) + yy;
        else        off = longint'(yy) * (longint'(1) << xb) + xx;
        off = off * (longint'(1) << (xs + ys));
        e.addr = 32'(longint'(o) * (longint'(1) << 29) + longint'(f) * (longint'(1) << 27) + off);
        return e;
    endfunction

    // Driver: one request per call, expected item pushed
    task automatic apply(input int f, input int o, input int x, input int y, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        fmt      = f[1:0];
        orient   = o[2:0];
        x_in     = x[15:0];
        y_in     = y[15:0];
        sb.push_back(model(f, o, x, y, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares each produced result against the queue head
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && out_valid && !done) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R9 unexpected out_valid: actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (addr !== e.addr || stride !== e.stride ||
                        range_err !== e.rerr || fmt_err !== e.ferr) begin
                        n_bad++;
                        $display("FAIL %s actual addr=%h stride=%h rerr=%b ferr=%b expected addr=%h stride=%h rerr=%b ferr=%b",
                                 e.tag, addr, stride, range_err, fmt_err,
                                 e.addr, e.stride, e.rerr, e.ferr);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset out_valid: actual %b expected 0", out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: format field for each tiled format
        apply(0, 0, 5, 7, "R1");
        apply(1, 0, 5, 7, "R1");
        apply(2, 0, 5, 7, "R1");
        idle(1);
        // R2: view field for several orientations
        apply(0, 3, 10, 20, "R2");
        apply(1, 5, 10, 20, "R2");
        apply(2, 6, 10, 20, "R2");
        apply(0, 7, 10, 20, "R2");
        // R3: unswapped packing and alignment
        apply(2, 0, 100, 200, "R3");
        apply(1, 0, 16383, 4095, "R3");
        apply(0, 0, 16383, 8191, "R3");
        idle(2);
        // R4: swapped packing
        apply(0, 4, 3, 9, "R4");
        apply(2, 4, 8191, 4095, "R4");
        apply(1, 4, 1234, 567, "R4");
        // R5: mirroring on each axis
        apply(0, 1, 0, 0, "R5");
        apply(0, 2, 0, 0, "R5");
        apply(2, 3, 8191, 4095, "R5");
        apply(1, 1, 77, 33, "R5");
        // R6: mask boundaries per format
        apply(0, 0, 16384, 0, "R6");
        apply(0, 0, 0, 8192, "R6");
        apply(2, 1, 8192, 0, "R6");
        apply(2, 0, 8191, 4096, "R6");
        apply(1, 4, 0, 4096, "R6");
        apply(1, 0, 16383, 4095, "R6");
        // R7: page mode refused
        apply(3, 0, 1, 1, "R7");
        apply(3, 5, 65535, 65535, "R7");
        idle(1);
        // R8: stride across all formats and orientations
        for (int f = 0; f < 4; f++)
            for (int o = 0; o < 8; o++)
                apply(f, o, 1, 2, "R8");
        // R9: gaps between requests
        apply(0, 0, 9, 9, "R9");
        idle(2);
        apply(2, 6, 4, 4, "R9");
        idle(4);

        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R9 results missing: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule